// File: doc/BRIEF.md
# Asynchronous SRAM Host Controller

This block sits between a synchronous request port and an external asynchronous static RAM organised as 128K bytes. A requester presents an operation with a valid/ready handshake. The operation carries a read/write flag, a 17-bit address and write data. The controller then plays the memory-side waveform and reports completion with a one-cycle done strobe. For a read, the captured byte is returned alongside that strobe.

On the memory side the block drives the address, two chip selects of opposite polarity, an active-low write strobe and an active-low output enable. It also drives a split tri-state data bus: an out value, a drive enable and an in value. Every phase length is counted in system clocks. These counts are computed at elaboration from nanosecond limits and the clock period, as ceil(limit / period), never less than 1:

- The read phase lasts max(cycle time, access time).
- The write-strobe phase lasts max(strobe width, address-to-end time, data setup).
- The write-hold phase lasts max(1, cycle count − strobe count).
- The turnaround lasts ceil(bus release time / period).

All memory-side outputs come straight from flops.

Top module: `sram_host_ctrl`

## Requirements
- R1: During and right after reset, req_ready is 1, rsp_done is 0, the memory is deselected (mem_ce1_n=1, mem_ce2=0), mem_we_n=1, mem_oe_n=1 and mem_dq_oe=0.
- R2: A read (req_write=0) keeps the memory selected with mem_we_n=1 and mem_oe_n=0 for N_RD cycles at a fixed address. It captures mem_dq_in on the last of them and returns that byte on rsp_rdata together with rsp_done, N_RD cycles after the accepting edge.
- R3: A write (req_write=1) holds mem_we_n low for exactly N_WE cycles, with the memory selected, mem_oe_n=1, mem_dq_oe=1, and address and data stable. mem_we_n then rises while both selects and the data drive stay active, and address and data are held for N_WH further cycles.
- R4: When a write follows a read, mem_dq_oe stays 0 with mem_oe_n=1 for at least N_TURN cycles before the write drives the bus. This adds N_TURN cycles to that write's latency.
- R5: mem_dq_oe=1 and mem_oe_n=0 never occur in the same cycle.
- R6: A request is accepted only on an edge where req_ready=1, which holds only when no operation is in progress. Requests and field values presented while busy have no effect on the memory or on the results.
- R7: With a 5 ns clock and limits of 12 ns cycle, 12 ns access, 10 ns strobe width, 10 ns address-to-end, 7 ns data setup and 7 ns release, the counts are N_RD=3, N_WE=2, N_WH=1 and N_TURN=2. A write completes in N_WE+N_WH cycles, or N_TURN+N_WE+N_WH cycles after a read.
- R8: A read returns the byte of the most recent write to the same address.
- R9: rsp_done is a single-cycle pulse, given exactly once per accepted operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_rdata | output | 8 | Read byte, valid with rsp_done |
| rsp_done | output | 1 | One-cycle completion strobe |
| mem_addr | output | 17 | Memory address |
| mem_ce1_n | output | 1 | Active-low chip select |
| mem_ce2 | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Data bus value to drive |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 8 | Data bus sampled value |

## Verification
The done strobe of one operation and the acceptance of the next can fall in the same cycle. This is because the controller returns to idle on the edge that raises done. The critical pairing is a read's done coinciding with the acceptance of a write, which must then take the turnaround path rather than driving the bus at once. The bench keeps req_valid high throughout, so every operation is accepted in the done cycle of its predecessor. It interleaves write and read to the same address across 256 data values. For each operation it judges the latency in cycles, the returned byte against its own shadow copy, and the count of output-enable-high cycles before each drive.

// File: rtl/sram_host_ctrl.sv
module sram_host_ctrl #(
  parameter int AW      = 17,
  parameter int DW      = 8,
  parameter int CLK_PS  = 5000,
  parameter int CYC_PS  = 12000,
  parameter int ACC_PS  = 12000,
  parameter int WEP_PS  = 10000,
  parameter int AWE_PS  = 10000,
  parameter int DS_PS   = 7000,
  parameter int TURN_PS = 7000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_done,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce1_n,
  output logic          mem_ce2,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);

  function automatic int clks(input int ps);
    int n;
    n = (ps + CLK_PS - 1) / CLK_PS;
    return (n < 1) ? 1 : n;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int N_CYC  = clks(CYC_PS);
  localparam int N_RD   = mx(clks(ACC_PS), N_CYC);
  localparam int N_WE   = mx(mx(clks(WEP_PS), clks(AWE_PS)), clks(DS_PS));
  localparam int N_WH   = (N_CYC - N_WE > 1) ? N_CYC - N_WE : 1;
  localparam int N_TURN = clks(TURN_PS);
  localparam int N_MAX  = mx(mx(N_RD, N_WE), mx(N_WH, N_TURN));
  localparam int CW     = $clog2(N_MAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_TURN, S_RD, S_WR, S_HOLD} st_t;

  st_t           st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic          rd_last;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdat_q, rdat_q;
  logic          done_q, sel_q, we_q, oe_q, dqoe_q;

  wire accept = req_valid && (st == S_IDLE);
  wire last   = (cnt == '0);

  always_comb begin
    st_n  = st;
    cnt_n = last ? cnt : cnt - 1'b1;
    case (st)
      S_IDLE:
        if (req_valid) begin
          if (!req_write) begin
            st_n = S_RD;   cnt_n = CW'(N_RD - 1);
          end else if (rd_last) begin
            st_n = S_TURN; cnt_n = CW'(N_TURN - 1);
          end else begin
            st_n = S_WR;   cnt_n = CW'(N_WE - 1);
          end
        end
      S_TURN: if (last) begin st_n = S_WR;   cnt_n = CW'(N_WE - 1); end
      S_RD:   if (last) st_n = S_IDLE;
      S_WR:   if (last) begin st_n = S_HOLD; cnt_n = CW'(N_WH - 1); end
      S_HOLD: if (last) st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      rd_last <= 1'b0;
      addr_q  <= '0;
      wdat_q  <= '0;
      rdat_q  <= '0;
      done_q  <= 1'b0;
      sel_q   <= 1'b0;
      we_q    <= 1'b0;
      oe_q    <= 1'b0;
      dqoe_q  <= 1'b0;
    end else begin
      st     <= st_n;
      cnt    <= cnt_n;
      done_q <= last && (st == S_RD || st == S_HOLD);
      sel_q  <= (st_n == S_RD) || (st_n == S_WR) || (st_n == S_HOLD);
      we_q   <= (st_n == S_WR);
      oe_q   <= (st_n == S_RD);
      dqoe_q <= (st_n == S_WR) || (st_n == S_HOLD);
      if (accept) begin
        addr_q <= req_addr;
        wdat_q <= req_wdata;
      end
      if (st == S_RD && last) begin
        rdat_q  <= mem_dq_in;
        rd_last <= 1'b1;
      end else if (st == S_WR) begin
        rd_last <= 1'b0;
      end
    end
  end

  assign req_ready  = (st == S_IDLE);
  assign rsp_done   = done_q;
  assign rsp_rdata  = rdat_q;
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdat_q;
  assign mem_ce1_n  = !sel_q;
  assign mem_ce2    = sel_q;
  assign mem_we_n   = !we_q;
  assign mem_oe_n   = !oe_q;
  assign mem_dq_oe  = dqoe_q;

endmodule

// File: rtl/sram_host_ctrl_chk.sv
module sram_host_ctrl_chk #(
  parameter int AW      = 17,
  parameter int DW      = 8,
  parameter int CLK_PS  = 5000,
  parameter int TURN_PS = 7000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_done,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce1_n,
  input logic          mem_ce2,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic [DW-1:0] mem_dq_out,
  input logic          mem_dq_oe
);
  localparam int TURN_RAW = (TURN_PS + CLK_PS - 1) / CLK_PS;
  localparam int TURN     = (TURN_RAW < 1) ? 1 : TURN_RAW;

  logic [7:0] gap;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         gap <= 8'hFF;
    else if (!mem_oe_n) gap <= 8'd0;
    else if (gap != 8'hFF) gap <= gap + 8'd1;
  end

  wire sel = !mem_ce1_n && mem_ce2;

  p_read_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (sel && mem_we_n));

  p_write_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (sel && mem_oe_n && mem_dq_oe));

  p_write_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |=> ($stable(mem_addr) && $stable(mem_dq_out)));

  p_write_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (sel && mem_dq_oe));

  p_turnaround_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (gap >= 8'(TURN)));

  p_no_contention_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n));

  p_ready_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!sel && mem_we_n && !mem_dq_oe));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
endmodule

bind sram_host_ctrl sram_host_ctrl_chk #(
  .AW(AW), .DW(DW), .CLK_PS(CLK_PS), .TURN_PS(TURN_PS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_done(rsp_done),
  .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2),
  .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out),
  .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_host_ctrl_test.sv
`timescale 1ns/1ps
module sram_host_ctrl_test;
  function automatic int cdiv(input int a, input int b);
    int n;
    n = (a + b - 1) / b;
    return (n < 1) ? 1 : n;
  endfunction
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int CP     = 5000;
  localparam int E_CYC  = cdiv(12000, CP);
  localparam int E_RD   = imax(cdiv(12000, CP), E_CYC);
  localparam int E_WE   = imax(imax(cdiv(10000, CP), cdiv(10000, CP)), cdiv(7000, CP));
  localparam int E_WH   = imax(1, E_CYC - E_WE);
  localparam int E_TURN = cdiv(7000, CP);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_done, mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0] rsp_rdata, mem_dq_out, mem_dq_in;
  logic [16:0] mem_addr;

  always #2.5 clk = ~clk;

  sram_host_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .mem_addr(mem_addr),
    .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  int nchk = 0, nfail = 0, cyc = 0, ndone = 0, nops = 0;
  bit finished = 0;
  logic [7:0] ram [int];
  logic [7:0] shadow [int];
  logic [7:0] dq_drv = 8'hEE;
  logic we_prev = 1'b1, dqoe_prev = 1'b0, clash = 1'b0;
  int gap = 100, we_len = 0;
  bit prev_rd = 0;

  assign mem_dq_in = dq_drv;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model and timing monitors, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_dq_oe && !dqoe_prev) chk(gap >= E_TURN, "R4 oe-high cycles before drive", gap, E_TURN);
      if (mem_dq_oe && !mem_oe_n) clash = 1'b1;
      if (!mem_we_n) we_len++;
      if (!we_prev && mem_we_n) begin
        chk(!mem_ce1_n && mem_ce2 && mem_dq_oe, "R3 select held at strobe rise", {mem_ce1_n, mem_ce2, mem_dq_oe}, 3'b011);
        chk(we_len == E_WE, "R3 strobe width", we_len, E_WE);
        ram[int'(mem_addr)] = mem_dq_out;
        we_len = 0;
      end
      if (rsp_done) ndone++;
    end
    gap = !mem_oe_n ? 0 : (gap < 100 ? gap + 1 : gap);
    we_prev = mem_we_n;
    dqoe_prev = mem_dq_oe;
    if (!mem_ce1_n && mem_ce2 && mem_we_n && !mem_oe_n)
      dq_drv = ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 8'h00;
    else
      dq_drv = 8'hEE;
  end

  // valid stays high: junk fields while busy must be ignored (R6)
  task automatic run(input bit w, input logic [16:0] a, input logic [7:0] d);
    int c0, lat, elat;
    bit busy_ok;
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    c0 = cyc;
    nops++;
    req_write = 1'b1; req_addr = ~a; req_wdata = ~d;
    busy_ok = 1;
    while (!rsp_done) begin
      if (req_ready) busy_ok = 0;
      @(negedge clk);
    end
    lat = cyc - c0;
    chk(busy_ok, "R6 ready low while busy", 0, 0);
    if (w) begin
      elat = (prev_rd ? E_TURN : 0) + E_WE + E_WH;
      chk(lat == elat, prev_rd ? "R4 R7 write-after-read latency" : "R3 R7 write latency", lat, elat);
      shadow[int'(a)] = d;
      prev_rd = 0;
    end else begin
      chk(lat == E_RD, "R2 R7 read latency", lat, E_RD);
      chk(rsp_rdata == shadow[int'(a)], "R2 R8 read data", rsp_rdata, shadow[int'(a)]);
      prev_rd = 1;
    end
  endtask

  task automatic finish_up;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog R9 actual=%0d expected=%0d", nops, ndone);
    finish_up();
  end

  initial begin
    logic [16:0] ea [6] = '{17'h00000, 17'h1FFFF, 17'h10000, 17'h0AAAA, 17'h15555, 17'h00001};
    logic [7:0]  ed [6] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_done && mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe,
        "R1 outputs in reset", {req_ready, rsp_done, mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe}, 7'b1010110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe,
        "R1 outputs after reset", {req_ready, mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe}, 6'b110110);
    // boundary addresses and data: write first (no turnaround), then read back
    for (int i = 0; i < 6; i++) run(1'b1, ea[i], ed[i]);
    for (int i = 0; i < 6; i++) run(1'b0, ea[i], 8'h00);
    // sweep every data value: write, read, next write follows a read (R4)
    for (int d = 0; d < 256; d++) begin
      run(1'b1, 17'((d * 1031 + 7) & 17'h1FFFF), 8'(d) ^ 8'h3C);
      run(1'b0, 17'((d * 1031 + 7) & 17'h1FFFF), 8'h00);
    end
    // back-to-back reads in reverse order (R8)
    for (int d = 255; d >= 0; d--) run(1'b0, 17'((d * 1031 + 7) & 17'h1FFFF), 8'h00);
    // back-to-back writes then reads, overwriting earlier data
    for (int i = 0; i < 16; i++) run(1'b1, 17'((i * 1031 + 7) & 17'h1FFFF), 8'(i * 17));
    for (int i = 0; i < 16; i++) run(1'b0, 17'((i * 1031 + 7) & 17'h1FFFF), 8'h00);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk(!clash, "R5 no drive while output enabled", clash, 0);
    chk(ndone == nops, "R9 one done pulse per operation", ndone, nops);
    chk(req_ready && mem_ce1_n && !mem_ce2, "R6 idle deselected", {req_ready, mem_ce1_n, mem_ce2}, 3'b110);
    finish_up();
  end
endmodule